// File: doc/BRIEF.md
# Dual-Channel SAR ADC Capture Controller

This block reads two SAR analog-to-digital converters, called X and Y, that share a single convert-start output and a single serial clock. Each converter returns its sample on its own data line. A conversion starts only on a PWM triangle-carrier event. The peak event and the valley event can each be enabled on its own. The block holds the convert-start line high for a programmed time, then waits out the conversion time. It then clocks both 18-bit results in at the same time, MSB first, at a serial clock rate set by software.

Each data line passes through a two-flop synchronizer before it is used. The done flag drops in the same cycle that convert-start rises. It rises again only when both results are complete, and both result registers load in that same cycle. Until then the previous pair of results stays readable. A carrier event that arrives while a capture is under way starts nothing. Instead it sets a sticky overrun flag, which software clears.

Top module: `dual_sar_capture`

## Requirements
- R1: After reset, cnv, sclk, done and overrun are 0, and result_x and result_y are 0.
- R2: When the block is idle, a start is either carrier_peak with peak_en=1 or carrier_valley with valley_en=1 at a clock edge. A start raises cnv at that edge. cnv then stays high for max(cnv_cycles,1) cycles.
- R3: sclk stays low while cnv is high and for max(conv_wait,1) cycles after cnv falls. Next come 18 serial clock periods. Each period is H cycles low followed by H cycles high, where H = max(sclk_half,2). After the 18th period, sclk idles low.
- R4: sclk_half, cnv_cycles and conv_wait are taken at the start edge. Changing them during a capture has no effect on that capture's timing.
- R5: done falls at the same edge that cnv rises, and it stays low throughout the wait and the serial transfer.
- R6: Bit 17 (MSB) comes first. Bit k of each channel is the synchronized data line sampled at the clock edge that ends the high phase of serial period k. The converter may change its data line after each falling edge of sclk.
- R7: done rises at the edge that ends the 18th high phase. result_x and result_y load together at that edge and change at no other time.
- R8: A start condition that occurs while a capture is in progress is ignored, and overrun is set to 1. This includes the edge at which done rises. overrun_clr clears overrun. When a set and a clear happen at the same edge, the set wins.
- R9: A carrier event whose enable is 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_peak | input | 1 | One-cycle pulse at the carrier peak |
| carrier_valley | input | 1 | One-cycle pulse at the carrier valley |
| peak_en | input | 1 | Allow peak events to start a conversion |
| valley_en | input | 1 | Allow valley events to start a conversion |
| sclk_half | input | CW | Serial clock half-period in clk cycles (clamped to at least 2) |
| cnv_cycles | input | CW | Convert-start high time in clk cycles (at least 1) |
| conv_wait | input | CW | Conversion wait after cnv falls, in clk cycles (at least 1) |
| overrun_clr | input | 1 | Clear the sticky overrun flag |
| miso_x | input | 1 | Serial data from converter X (asynchronous) |
| miso_y | input | 1 | Serial data from converter Y (asynchronous) |
| cnv | output | 1 | Shared convert-start |
| sclk | output | 1 | Shared serial clock |
| done | output | 1 | Both results valid |
| overrun | output | 1 | Sticky dropped-start flag |
| result_x | output | DW | Last complete X sample |
| result_y | output | DW | Last complete Y sample |

## Verification
Some properties are checked on every cycle by assertions:
- done is low whenever cnv rises.
- sclk is quiet outside the transfer.
- The latched half-period is never below 2.
- A start while busy always leaves overrun set.
- The result registers move only in the cycle done rises.

Other behaviour only the bench scenarios can show:
- The exact cycle positions of every sclk edge.
- The bit order and sampling point of the captured words against a converter model that changes its output after each falling edge.
- Clamping of small settings.
- That changing the settings during a capture leaves its length unchanged.

// File: rtl/sarcap_pkg.sv
package sarcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CNV  = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } seq_state_e;

    localparam int unsigned DEF_DW = 18;
    localparam int unsigned DEF_CW = 8;
    localparam int unsigned N_CH   = 2;
    localparam int unsigned MIN_HALF = 2;
    localparam int unsigned MIN_LEN  = 1;
endpackage

// File: rtl/sarcap_sync.sv
module sarcap_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);
    logic [N-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/sarcap_seq.sv
module sarcap_seq
    import sarcap_pkg::*;
#(
    parameter int unsigned DW = DEF_DW,
    parameter int unsigned CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [CW-1:0] sclk_half,
    input  logic [CW-1:0] cnv_cycles,
    input  logic [CW-1:0] conv_wait,
    input  logic          overrun_clr,
    output logic          cnv,
    output logic          sclk,
    output logic          done,
    output logic          overrun,
    output logic          sample_en,
    output logic          last_bit
);
    localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1;

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] half_q;
    logic [CW-1:0] wait_q;
    logic [CW-1:0] ph;
    logic [BW-1:0] bitc;
    logic [CW-1:0] half_eff, cnv_eff, wait_eff;

    always_comb begin
        half_eff = (sclk_half < CW'(MIN_HALF)) ? CW'(MIN_HALF) : sclk_half;
        cnv_eff  = (cnv_cycles < CW'(MIN_LEN)) ? CW'(MIN_LEN) : cnv_cycles;
        wait_eff = (conv_wait < CW'(MIN_LEN)) ? CW'(MIN_LEN) : conv_wait;
    end

    assign sample_en = (state == ST_XFER) && (ph == '0) && sclk;
    assign last_bit  = sample_en && (bitc == BW'(DW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            half_q <= CW'(MIN_HALF);
            wait_q <= CW'(MIN_LEN);
            ph     <= '0;
            bitc   <= '0;
            cnv    <= 1'b0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (trig) begin
                    state  <= ST_CNV;
                    cnt    <= cnv_eff - CW'(1);
                    half_q <= half_eff;
                    wait_q <= wait_eff;
                    cnv    <= 1'b1;
                    done   <= 1'b0;
                end
                ST_CNV: begin
                    if (cnt == '0) begin
                        state <= ST_WAIT;
                        cnv   <= 1'b0;
                        cnt   <= wait_q - CW'(1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) begin
                        state <= ST_XFER;
                        ph    <= half_q - CW'(1);
                        bitc  <= '0;
                        sclk  <= 1'b0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_XFER: begin
                    if (ph != '0) begin
                        ph <= ph - CW'(1);
                    end else if (!sclk) begin
                        sclk <= 1'b1;
                        ph   <= half_q - CW'(1);
                    end else begin
                        sclk <= 1'b0;
                        ph   <= half_q - CW'(1);
                        if (bitc == BW'(DW - 1)) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            bitc <= bitc + BW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                            overrun <= 1'b0;
        else if (trig && state != ST_IDLE)  overrun <= 1'b1;
        else if (overrun_clr)               overrun <= 1'b0;
    end

    p_cnv_done_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv) |-> !done);
    p_cnv_from_trig_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv) |-> $past(trig));
    p_quiet_sclk_r3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_XFER) |-> !sclk);
    p_half_min_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER) |-> (half_q >= CW'(MIN_HALF)));
    p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        (trig && state != ST_IDLE) |=> overrun);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_IDLE));
endmodule

// File: rtl/sarcap_shift.sv
module sarcap_shift #(
    parameter int unsigned DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_en,
    input  logic          last_bit,
    input  logic          bit_in,
    output logic [DW-1:0] result
);
    logic [DW-1:0] sh;
    logic [DW-1:0] sh_next;

    assign sh_next = {sh[DW-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            result <= '0;
        end else if (sample_en) begin
            sh <= sh_next;
            if (last_bit) result <= sh_next;
        end
    end

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(last_bit) |-> $stable(result));
endmodule

// File: rtl/dual_sar_capture.sv
module dual_sar_capture
    import sarcap_pkg::*;
#(
    parameter int unsigned DW = DEF_DW,
    parameter int unsigned CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          carrier_peak,
    input  logic          carrier_valley,
    input  logic          peak_en,
    input  logic          valley_en,
    input  logic [CW-1:0] sclk_half,
    input  logic [CW-1:0] cnv_cycles,
    input  logic [CW-1:0] conv_wait,
    input  logic          overrun_clr,
    input  logic          miso_x,
    input  logic          miso_y,
    output logic          cnv,
    output logic          sclk,
    output logic          done,
    output logic          overrun,
    output logic [DW-1:0] result_x,
    output logic [DW-1:0] result_y
);
    logic                trig;
    logic                sample_en;
    logic                last_bit;
    logic [N_CH-1:0]     miso_sync;
    logic [DW-1:0]       res [N_CH];

    assign trig = (carrier_peak & peak_en) | (carrier_valley & valley_en);

    sarcap_sync #(.N(N_CH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({miso_y, miso_x}),
        .d_sync  (miso_sync)
    );

    sarcap_seq #(.DW(DW), .CW(CW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .trig        (trig),
        .sclk_half   (sclk_half),
        .cnv_cycles  (cnv_cycles),
        .conv_wait   (conv_wait),
        .overrun_clr (overrun_clr),
        .cnv         (cnv),
        .sclk        (sclk),
        .done        (done),
        .overrun     (overrun),
        .sample_en   (sample_en),
        .last_bit    (last_bit)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        sarcap_shift #(.DW(DW)) u_shift (
            .clk       (clk),
            .rst       (rst),
            .sample_en (sample_en),
            .last_bit  (last_bit),
            .bit_in    (miso_sync[ch]),
            .result    (res[ch])
        );
    end

    assign result_x = res[0];
    assign result_y = res[1];

    p_pair_update_r7: assert property (@(posedge clk) disable iff (rst)
        (result_x != $past(result_x) || result_y != $past(result_y)) |-> (done && !$past(done)));
endmodule

// File: tb/dual_sar_capture_tb.sv
module dual_sar_capture_tb;
    localparam int DW = 18;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic carrier_peak = 1'b0, carrier_valley = 1'b0;
    logic peak_en = 1'b0, valley_en = 1'b0;
    logic [CW-1:0] sclk_half = 8'd2, cnv_cycles = 8'd2, conv_wait = 8'd4;
    logic overrun_clr = 1'b0;
    logic miso_x = 1'b0, miso_y = 1'b0;
    logic cnv, sclk, done, overrun;
    logic [DW-1:0] result_x, result_y;

    always #2 clk = ~clk;

    dual_sar_capture #(.DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .carrier_peak(carrier_peak), .carrier_valley(carrier_valley),
        .peak_en(peak_en), .valley_en(valley_en), .sclk_half(sclk_half),
        .cnv_cycles(cnv_cycles), .conv_wait(conv_wait), .overrun_clr(overrun_clr),
        .miso_x(miso_x), .miso_y(miso_y), .cnv(cnv), .sclk(sclk), .done(done),
        .overrun(overrun), .result_x(result_x), .result_y(result_y)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // converter words driven by the converter model
    logic [DW-1:0] wx = '0, wy = '0;

    // behavioural reference model
    bit m_busy = 0, m_done = 0, m_ovr = 0;
    int m_e = 0, m_c = 1, m_w = 1, m_h = 2;
    logic [DW-1:0] m_rx = '0, m_ry = '0, m_lx = '0, m_ly = '0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_ovr = 0; m_e = 0;
            m_rx = '0; m_ry = '0;
        end else begin
            bit t;
            t = (carrier_peak && peak_en) || (carrier_valley && valley_en);
            if (m_busy) begin
                if (t) m_ovr = 1; else if (overrun_clr) m_ovr = 0;
                m_e++;
                if (m_e == m_c + m_w + 2 * DW * m_h) begin
                    m_busy = 0; m_done = 1; m_rx = m_lx; m_ry = m_ly;
                end
            end else begin
                if (overrun_clr) m_ovr = 0;
                if (t) begin
                    m_busy = 1; m_e = 0; m_done = 0;
                    m_c = (cnv_cycles < 1) ? 1 : int'(cnv_cycles);
                    m_w = (conv_wait < 1) ? 1 : int'(conv_wait);
                    m_h = (sclk_half < 2) ? 2 : int'(sclk_half);
                    m_lx = wx; m_ly = wy;
                end
            end
        end
    end

    function automatic bit exp_sclk();
        int x;
        if (!m_busy) return 0;
        x = m_e - m_c - m_w;
        if (x < 0) return 0;
        return (x % (2 * m_h)) >= m_h;
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(cnv == (m_busy && m_e < m_c), "R2 cnv", cnv, m_busy && m_e < m_c);
            chk(sclk == exp_sclk(), "R3 sclk", sclk, exp_sclk());
            chk(done == m_done, "R5 done", done, m_done);
            chk(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
            chk(result_x == m_rx, "R6 result_x", result_x, m_rx);
            chk(result_y == m_ry, "R7 result_y", result_y, m_ry);
        end
    end

    // converter model: MSB valid after convert-start, next bit after each sclk fall
    int idx = 0;
    logic prev_sclk = 1'b0;
    always @(negedge clk) begin
        if (cnv) idx = 0;
        else if (prev_sclk && !sclk) idx++;
        prev_sclk = sclk;
        miso_x <= (idx < DW) ? wx[DW-1-idx] : 1'b0;
        miso_y <= (idx < DW) ? wy[DW-1-idx] : 1'b0;
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic pulse(input bit pk, input bit vl);
        @(negedge clk);
        carrier_peak = pk; carrier_valley = vl;
        @(negedge clk);
        carrier_peak = 0; carrier_valley = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        do begin @(negedge clk); n++; end while (!done && n < 5000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!cnv && !sclk && !done && !overrun && result_x == 0 && result_y == 0,
            "R1 reset state", {cnv, sclk, done, overrun}, 0);

        // peak trigger, minimum half period
        peak_en = 1; wx = 18'h2A5C3; wy = 18'h1F00F;
        pulse(1, 0);
        wait_done();
        repeat (3) @(negedge clk);
        chk(result_x == 18'h2A5C3, "R6 x word", result_x, 18'h2A5C3);

        // disabled valley
        wx = 18'h3FFFF; wy = 18'h00001;
        pulse(0, 1);
        repeat (4) @(negedge clk);
        chk(!cnv && done, "R9 disabled valley", cnv, 0);

        // valley enabled, clamped settings
        valley_en = 1; peak_en = 0; sclk_half = 0; cnv_cycles = 0; conv_wait = 0;
        pulse(0, 1);
        wait_done();
        repeat (2) @(negedge clk);

        // slower clock; settings changed and triggers fired mid-capture
        begin
            int n;
            peak_en = 1; sclk_half = 5; cnv_cycles = 3; conv_wait = 10;
            wx = 18'h15555; wy = 18'h2AAAA;
            @(negedge clk);
            carrier_peak = 1;
            @(negedge clk);
            carrier_peak = 0; sclk_half = 1; cnv_cycles = 9; conv_wait = 2;
            n = 1;
            repeat (20) begin @(negedge clk); n++; end
            carrier_valley = 1;
            @(negedge clk); n++;
            carrier_valley = 0;
            repeat (10) begin @(negedge clk); n++; end
            carrier_peak = 1; overrun_clr = 1;
            @(negedge clk); n++;
            carrier_peak = 0; overrun_clr = 0;
            chk(overrun == 1, "R8 set wins over clear", overrun, 1);
            while (!done && n < 5000) begin @(negedge clk); n++; end
            chk(n == 3 + 10 + 2 * DW * 5 + 1, "R4 latched timing", n, 3 + 10 + 2 * DW * 5 + 1);
        end
        overrun_clr = 1;
        @(negedge clk);
        overrun_clr = 0;
        @(negedge clk);
        chk(overrun == 0, "R8 clear", overrun, 0);

        // both events together, then a back-to-back start right after done
        sclk_half = 3; cnv_cycles = 2; conv_wait = 3;
        wx = 18'h0000F; wy = 18'h3C000;
        pulse(1, 1);
        wait_done();
        wx = 18'h12345; wy = 18'h0ABCD;
        pulse(1, 0);
        wait_done();
        repeat (3) @(negedge clk);
        chk(result_y == 18'h0ABCD, "R7 y word", result_y, 18'h0ABCD);
        report();
    end
endmodule